// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Decoder

This block takes a 64-bit interrupt command written by one processor and turns it into deliveries for the other processors in the system. Software writes the command as two 32-bit halves, or as one 64-bit word when the wide register mode is selected. Fixed-vector commands and non-maskable commands go to a set of processors chosen by a shorthand field. All deliveries for one command come out together as registered one-cycle pulses in the cycle after the triggering write.

Two other command kinds, INIT and STARTUP, drive a small boot handshake that the block keeps for each processor. A processor is in one of three states: halted in INIT, waiting for a startup command, or running. Only processor 0 may move another processor along this path. A successful STARTUP produces a start event that carries the target ID and a page-aligned start address. The current running and waiting sets are visible as masks.

Top module: `ipi_cmd_decoder`

## Requirements
- R1: After reset, all delivery outputs and the start event are zero. Processor 0 is running and every other processor is in INIT, so `run_mask` is 1 and `wait_mask` is 0.
- R2: When `wide_mode` is 0, a high-half write (`wr_hi_en`) stores `wr_data[31:0]` and produces no output. A low-half write (`wr_lo_en`) forms the command {stored high, `wr_data[31:0]`} and executes it.
- R3: When `wide_mode` is 1, a low-half write executes `wr_data[63:0]` as the whole command. A high-half write changes nothing, and a later narrow-mode command still uses the high half stored before.
- R4: Command fields are: destination ID at bits 63:56, vector at bits 7:0, delivery mode at bits 10:8, level at bit 14 (1 = assert), and shorthand at bits 19:18.
- R5: The shorthand selects the target set. 0 selects only the destination ID, and an ID at or above the processor count gives an empty set. 1 selects only the sender `src_cpu`. 2 selects every processor set in `active_mask`. 3 selects every processor set in `active_mask` except the sender.
- R6: Mode 0 (fixed) raises `fix_req` for each processor in the set and places the vector on `fix_vec`. Both appear in the cycle after the low write, and `fix_req` lasts one cycle.
- R7: Mode 4 (NMI) raises `nmi_pulse` for each processor in the set for one cycle, in the cycle after the low write.
- R8: A mode 5 (INIT) command whose level bit is 0 has no effect.
- R9: INIT and STARTUP act only when `src_cpu` is 0 and the destination ID is nonzero and below the processor count. Their shorthand field is ignored.
- R10: A valid INIT moves a target in INIT to the waiting state. A target that is waiting or running does not change.
- R11: A valid mode 6 (STARTUP) sent to a waiting target makes it running. In the next cycle it also pulses `start_valid` with `start_cpu` set to the destination and `start_addr` set to the vector shifted left by 12. A STARTUP sent to a target in any other state is ignored.
- R12: Delivery modes other than 0, 4, 5 and 6 produce no output and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1: a low write carries the full 64-bit command |
| wr_hi_en | input | 1 | High-half write strobe |
| wr_lo_en | input | 1 | Low-half write strobe; triggers the command |
| wr_data | input | 64 | Write data |
| src_cpu | input | CPU_W | ID of the sending processor |
| active_mask | input | NUM_CPU | Processors counted as active |
| fix_req | output | NUM_CPU | Fixed-interrupt request pulses |
| fix_vec | output | 8 | Vector of the last fixed command |
| nmi_pulse | output | NUM_CPU | NMI pulses |
| start_valid | output | 1 | Start event pulse |
| start_cpu | output | 8 | Processor being started |
| start_addr | output | 20 | Start address (vector << 12) |
| run_mask | output | NUM_CPU | Processors in the running state |
| wait_mask | output | NUM_CPU | Processors waiting for STARTUP |

## Verification
The hardest state to reach is a target that is waiting for STARTUP and then receives a command that must be ignored. Reaching it takes a full INIT from processor 0 first. The stimulus then sends repeated INITs, STARTUPs from a non-boot sender, and STARTUPs to targets still in INIT before the honoured STARTUP arrives. The stored high half in narrow mode is tested the same way: a wide-mode high write lands between a narrow high write and the narrow low write that consumes it.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int VEC_W      = 8;
  localparam int DEST_W     = 8;
  localparam int PAGE_SHIFT = 12;
  localparam int ADDR_W     = VEC_W + PAGE_SHIFT;

  localparam logic [2:0] DM_FIXED = 3'd0;
  localparam logic [2:0] DM_NMI   = 3'd4;
  localparam logic [2:0] DM_INIT  = 3'd5;
  localparam logic [2:0] DM_START = 3'd6;

  localparam logic [1:0] SH_DEST   = 2'd0;
  localparam logic [1:0] SH_SELF   = 2'd1;
  localparam logic [1:0] SH_ALL    = 2'd2;
  localparam logic [1:0] SH_OTHERS = 2'd3;

  typedef enum logic [1:0] {
    BOOT_HALT = 2'd0,
    BOOT_WAIT = 2'd1,
    BOOT_RUN  = 2'd2
  } boot_e;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [VEC_W-1:0]  vec;
    logic [2:0]        mode;
    logic              level;
    logic [1:0]        sh;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [63:0] w);
    cmd_t c;
    c.dest  = w[63:56];
    c.vec   = w[7:0];
    c.mode  = w[10:8];
    c.level = w[14];
    c.sh    = w[19:18];
    return c;
  endfunction
endpackage

// File: rtl/ipi_cmd_latch.sv
module ipi_cmd_latch (
  input  logic        clk,
  input  logic        rst,
  input  logic        wide_mode,
  input  logic        wr_hi_en,
  input  logic        wr_lo_en,
  input  logic [63:0] wr_data,
  output logic        cmd_valid,
  output logic [63:0] cmd_word
);
  logic [31:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
    end else if (wr_hi_en && !wide_mode) begin
      hi_q <= wr_data[31:0];
    end
  end

  always_comb begin
    cmd_valid = wr_lo_en;
    cmd_word  = wide_mode ? wr_data : {hi_q, wr_data[31:0]};
  end
endmodule

// File: rtl/ipi_dest_set.sv
module ipi_dest_set #(
  parameter int NUM_CPU = 8,
  parameter int CPU_W   = 3,
  parameter int DEST_W  = 8
) (
  input  logic [1:0]         sh,
  input  logic [DEST_W-1:0]  dest,
  input  logic [CPU_W-1:0]   self_id,
  input  logic [NUM_CPU-1:0] active,
  output logic [NUM_CPU-1:0] targets
);
  import ipi_pkg::*;

  logic [NUM_CPU-1:0] dest_oh;
  logic [NUM_CPU-1:0] self_oh;

  always_comb begin
    for (int i = 0; i < NUM_CPU; i++) begin
      dest_oh[i] = (int'(dest) == i);
      self_oh[i] = (int'(self_id) == i);
    end
    unique case (sh)
      SH_DEST:   targets = dest_oh;
      SH_SELF:   targets = self_oh;
      SH_ALL:    targets = active;
      default:   targets = active & ~self_oh;
    endcase
  end
endmodule

// File: rtl/ipi_boot_fsm.sv
module ipi_boot_fsm #(
  parameter bit START_RUNNING = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_init,
  input  logic          go_start,
  output ipi_pkg::boot_e state
);
  import ipi_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= START_RUNNING ? BOOT_RUN : BOOT_HALT;
    end else begin
      unique case (state)
        BOOT_HALT: if (go_init)  state <= BOOT_WAIT;
        BOOT_WAIT: if (go_start) state <= BOOT_RUN;
        default:   state <= state;
      endcase
    end
  end
endmodule

// File: rtl/ipi_cmd_decoder.sv
module ipi_cmd_decoder #(
  parameter int NUM_CPU = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wide_mode,
  input  logic                       wr_hi_en,
  input  logic                       wr_lo_en,
  input  logic [63:0]                wr_data,
  input  logic [CPU_W-1:0]           src_cpu,
  input  logic [NUM_CPU-1:0]         active_mask,
  output logic [NUM_CPU-1:0]         fix_req,
  output logic [7:0]                 fix_vec,
  output logic [NUM_CPU-1:0]         nmi_pulse,
  output logic                       start_valid,
  output logic [7:0]                 start_cpu,
  output logic [19:0]                start_addr,
  output logic [NUM_CPU-1:0]         run_mask,
  output logic [NUM_CPU-1:0]         wait_mask
);
  import ipi_pkg::*;

  logic               cmd_valid;
  logic [63:0]        cmd_word;
  cmd_t               cmd;
  logic [NUM_CPU-1:0] targets;
  logic [NUM_CPU-1:0] tgt_oh;
  logic [NUM_CPU-1:0] go_init;
  logic [NUM_CPU-1:0] go_start;
  logic               boot_ok;
  logic               init_hit;
  logic               start_hit;
  logic               fix_hit;
  logic               nmi_hit;

  ipi_cmd_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .wide_mode (wide_mode),
    .wr_hi_en  (wr_hi_en),
    .wr_lo_en  (wr_lo_en),
    .wr_data   (wr_data),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word)
  );

  assign cmd = unpack_cmd(cmd_word);

  ipi_dest_set #(
    .NUM_CPU (NUM_CPU),
    .CPU_W   (CPU_W),
    .DEST_W  (DEST_W)
  ) u_dest (
    .sh      (cmd.sh),
    .dest    (cmd.dest),
    .self_id (src_cpu),
    .active  (active_mask),
    .targets (targets)
  );

  always_comb begin
    for (int i = 0; i < NUM_CPU; i++) begin
      tgt_oh[i] = (int'(cmd.dest) == i);
    end
    boot_ok   = (src_cpu == '0) && (cmd.dest != '0) && (int'(cmd.dest) < NUM_CPU);
    fix_hit   = cmd_valid && (cmd.mode == DM_FIXED);
    nmi_hit   = cmd_valid && (cmd.mode == DM_NMI);
    init_hit  = cmd_valid && (cmd.mode == DM_INIT) && cmd.level && boot_ok;
    start_hit = cmd_valid && (cmd.mode == DM_START) && boot_ok;
    go_init   = init_hit  ? tgt_oh : '0;
    go_start  = start_hit ? (tgt_oh & wait_mask) : '0;
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_boot
    boot_e st;
    ipi_boot_fsm #(.START_RUNNING(g == 0)) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .go_init  (go_init[g]),
      .go_start (go_start[g]),
      .state    (st)
    );
    assign run_mask[g]  = (st == BOOT_RUN);
    assign wait_mask[g] = (st == BOOT_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_req     <= '0;
      fix_vec     <= '0;
      nmi_pulse   <= '0;
      start_valid <= 1'b0;
      start_cpu   <= '0;
      start_addr  <= '0;
    end else begin
      fix_req     <= fix_hit ? targets : '0;
      nmi_pulse   <= nmi_hit ? targets : '0;
      start_valid <= |go_start;
      if (fix_hit) fix_vec <= cmd.vec;
      if (|go_start) begin
        start_cpu  <= cmd.dest;
        start_addr <= {cmd.vec, {PAGE_SHIFT{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/ipi_cmd_decoder_chk.sv
module ipi_cmd_decoder_chk #(
  parameter int NUM_CPU = 8,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_lo_en,
  input logic [CPU_W-1:0]   src_cpu,
  input logic [NUM_CPU-1:0] fix_req,
  input logic [NUM_CPU-1:0] nmi_pulse,
  input logic               start_valid,
  input logic [7:0]         start_cpu,
  input logic [NUM_CPU-1:0] run_mask,
  input logic [NUM_CPU-1:0] wait_mask
);
  AST_FIX_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    (fix_req != '0) |-> $past(wr_lo_en)); // R6
  AST_NMI_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    (nmi_pulse != '0) |-> $past(wr_lo_en)); // R7
  AST_START_FROM_BSP: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> ($past(wr_lo_en) && ($past(src_cpu) == '0))); // R9
  AST_START_TARGET_RANGE: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> ((start_cpu != 8'd0) && (int'(start_cpu) < NUM_CPU))); // R9
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((run_mask & $past(run_mask)) == $past(run_mask))); // R11
  AST_STATE_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    ((run_mask & wait_mask) == '0)); // R10
  AST_NEW_WAIT_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    ((wait_mask & ~$past(wait_mask)) != '0) |-> $past(wr_lo_en)); // R10
  AST_BSP_RUNNING: assert property (@(posedge clk) disable iff (rst)
    run_mask[0]); // R1
endmodule

bind ipi_cmd_decoder ipi_cmd_decoder_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_lo_en    (wr_lo_en),
  .src_cpu     (src_cpu),
  .fix_req     (fix_req),
  .nmi_pulse   (nmi_pulse),
  .start_valid (start_valid),
  .start_cpu   (start_cpu),
  .run_mask    (run_mask),
  .wait_mask   (wait_mask)
);

// File: tb/ipi_cmd_decoder_tb.sv
`timescale 1ns/1ps
module ipi_cmd_decoder_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wide_mode = 1'b0;
  logic         wr_hi_en = 1'b0;
  logic         wr_lo_en = 1'b0;
  logic [63:0]  wr_data = '0;
  logic [2:0]   src_cpu = '0;
  logic [N-1:0] active_mask = '0;
  logic [N-1:0] fix_req, nmi_pulse, run_mask, wait_mask;
  logic [7:0]   fix_vec, start_cpu;
  logic [19:0]  start_addr;
  logic         start_valid;

  always #2.5 clk = ~clk;

  ipi_cmd_decoder #(.NUM_CPU(N)) dut_i (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .wr_hi_en(wr_hi_en),
    .wr_lo_en(wr_lo_en), .wr_data(wr_data), .src_cpu(src_cpu),
    .active_mask(active_mask), .fix_req(fix_req), .fix_vec(fix_vec),
    .nmi_pulse(nmi_pulse), .start_valid(start_valid), .start_cpu(start_cpu),
    .start_addr(start_addr), .run_mask(run_mask), .wait_mask(wait_mask)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string cur_tag  = "R1";

  // behavioural reference model
  logic [31:0]  m_hi;
  logic [N-1:0] m_fix, m_nmi;
  logic [7:0]   m_vec, m_scpu;
  logic [19:0]  m_saddr;
  logic         m_sv;
  int           m_boot [N];   // 0 halted, 1 waiting, 2 running

  always @(posedge clk) begin
    if (rst) begin
      m_hi = '0; m_fix = '0; m_nmi = '0; m_vec = '0; m_scpu = '0;
      m_saddr = '0; m_sv = 0;
      for (int i = 0; i < N; i++) m_boot[i] = (i == 0) ? 2 : 0;
    end else begin
      m_fix = '0; m_nmi = '0; m_sv = 0;
      if (wr_lo_en) begin
        logic [63:0]  c;
        logic [N-1:0] s;
        int d, md;
        bit ok;
        c  = wide_mode ? wr_data : {m_hi, wr_data[31:0]};
        d  = int'(c[63:56]);
        md = int'(c[10:8]);
        for (int i = 0; i < N; i++) begin
          case (c[19:18])
            2'd0: s[i] = (i == d);
            2'd1: s[i] = (i == int'(src_cpu));
            2'd2: s[i] = active_mask[i];
            default: s[i] = active_mask[i] && (i != int'(src_cpu));
          endcase
        end
        ok = (src_cpu == 0) && (d != 0) && (d < N);
        if (md == 0) begin m_fix = s; m_vec = c[7:0]; end
        if (md == 4) m_nmi = s;
        if (md == 5 && c[14] && ok && m_boot[d] == 0) m_boot[d] = 1;
        if (md == 6 && ok && m_boot[d] == 1) begin
          m_boot[d] = 2; m_sv = 1; m_scpu = c[63:56]; m_saddr = {c[7:0], 12'h000};
        end
      end
      if (wr_hi_en && !wide_mode) m_hi = wr_data[31:0];
    end
  end

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [N-1:0] r, w;
      for (int i = 0; i < N; i++) begin r[i] = (m_boot[i] == 2); w[i] = (m_boot[i] == 1); end
      check("fix_req", fix_req, m_fix);
      check("fix_vec", fix_vec, m_vec);
      check("nmi_pulse", nmi_pulse, m_nmi);
      check("start_valid", start_valid, m_sv);
      if (m_sv) begin
        check("start_cpu", start_cpu, m_scpu);
        check("start_addr", start_addr, m_saddr);
      end
      check("run_mask", run_mask, r);
      check("wait_mask", wait_mask, w);
    end
  end

  function automatic logic [63:0] mk(int dest, int sh, int lvl, int md, int vec);
    logic [63:0] c = '0;
    c[63:56] = dest[7:0]; c[19:18] = sh[1:0]; c[14] = lvl[0];
    c[10:8] = md[2:0]; c[7:0] = vec[7:0];
    return c;
  endfunction

  task automatic wr_hi(input logic [31:0] d);
    @(negedge clk); wr_hi_en = 1; wr_data = {32'h0, d};
    @(negedge clk); wr_hi_en = 0; wr_data = '0;
  endtask

  task automatic wr_lo(input logic [63:0] d);
    @(negedge clk); wr_lo_en = 1; wr_data = d;
    @(negedge clk); wr_lo_en = 0; wr_data = '0;
  endtask

  // full narrow command: high half then low half
  task automatic send(input logic [63:0] c);
    wr_hi(c[63:32]); wr_lo({32'h0, c[31:0]});
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1; n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_tag = "R1";
    check("reset run_mask", run_mask, 8'h01);
    check("reset wait_mask", wait_mask, 8'h00);
    check("reset fix_req", fix_req, 8'h00);
    active_mask = 8'h0F;

    cur_tag = "R2";   // split write: high latches only
    send(mk(3, 0, 0, 0, 8'h41));
    check("R2 narrow fixed", 0, 0);
    cur_tag = "R4";
    send(mk(6, 0, 0, 0, 8'hE7));

    cur_tag = "R3";   // wide write, then wide-mode high write ignored
    wide_mode = 1;
    wr_lo(mk(5, 0, 0, 0, 8'h22));
    wr_hi(32'h0700_0000);
    wide_mode = 0;
    wr_lo({32'h0, mk(0, 0, 0, 0, 8'h33)});   // uses high stored at dest 6

    cur_tag = "R5";
    src_cpu = 2; send(mk(0, 1, 0, 0, 8'h50));
    send(mk(0, 2, 0, 0, 8'h51));
    src_cpu = 1; send(mk(0, 3, 0, 0, 8'h52));
    send(mk(9, 0, 0, 0, 8'h53));

    cur_tag = "R6";
    src_cpu = 0; send(mk(7, 0, 0, 0, 8'hFF));
    cur_tag = "R7";
    send(mk(0, 2, 0, 4, 8'h02));
    src_cpu = 3; send(mk(0, 3, 0, 4, 8'h02));

    cur_tag = "R8";
    src_cpu = 0; send(mk(2, 0, 0, 5, 0));
    cur_tag = "R9";
    src_cpu = 1; send(mk(2, 0, 1, 5, 0));
    src_cpu = 0; send(mk(0, 0, 1, 5, 0));
    send(mk(8, 0, 1, 5, 0));
    cur_tag = "R10";
    send(mk(2, 3, 1, 5, 0));
    send(mk(2, 0, 1, 5, 0));
    check("R10 wait after INIT", wait_mask, 8'h04);

    cur_tag = "R11";
    send(mk(3, 0, 0, 6, 8'h11));
    src_cpu = 1; send(mk(2, 0, 0, 6, 8'h12));
    src_cpu = 0; send(mk(2, 1, 0, 6, 8'h9A));
    check("R11 run after STARTUP", run_mask, 8'h05);
    send(mk(2, 0, 0, 6, 8'h9B));
    send(mk(2, 0, 1, 5, 0));

    cur_tag = "R12";
    send(mk(3, 2, 1, 1, 8'h44));
    send(mk(3, 2, 1, 7, 8'h45));
    send(mk(3, 2, 1, 2, 8'h46));
    check("R12 masks unchanged", {run_mask, wait_mask}, 16'h0500);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule